// File: doc/BRIEF.md
# Twisted-Ring Pattern Sequencing Controller

This block sequences a scan register used as a twisted-ring test pattern source. For every seed it first asks for the seed to be shifted in serially, which takes n cycles. It then runs n rounds. Each round is 2n cycles of twisting, where the register is a ring with an inverted feedback bit, followed by a single cycle of plain rotation. One seed therefore yields 2n²+n applied patterns after its n load cycles. After the n-th rotation the block pulses a seed-advance strobe so that the seed source moves on to the next seed.

Software or a test controller writes the number of seeds and pulses a start strobe. The block then runs all seeds back to back. It raises a done flag when the last seed's sequence ends, and it then parks the register in hold. The controller is a Moore machine with two state bits. Twist, load and rotate lengths come from enabled counters whose widths follow from n alone.

Top module: `bist_seq_ctrl`

## Requirements
- R1: After synchronous active-low reset, state_o is 2'b00, reg_op_o is 2'b00 (hold), done_o is 0 and twist_cnt_en_o, shift_cnt_en_o, seed_adv_o and pat_valid_o are all 0.
- R2: A start_i sampled while idle with a nonzero seed_count_i begins loading in the next cycle. The load phase lasts exactly N cycles with state_o = 2'b00 and reg_op_o = 2'b01 (serial load).
- R3: Each twist burst lasts exactly 2N cycles with reg_op_o = 2'b10 and twist_cnt_en_o = 1. state_o is 2'b01 for the first N cycles of the burst and 2'b10 for the last N.
- R4: A rotate lasts exactly one cycle with state_o = 2'b11, reg_op_o = 2'b11 and shift_cnt_en_o = 1. It is followed by another twist burst unless it was the N-th rotate of the seed.
- R5: After the N-th rotate the seed ends and the next seed's load begins, so each seed occupies 2N²+2N non-hold cycles. seed_adv_o is high exactly in the last rotate cycle of each seed.
- R6: pat_valid_o is high in every twist and rotate cycle and low in load and idle cycles.
- R7: One cycle after the last rotate of seed number seed_count_i, done_o is 1, reg_op_o is hold and state_o is 2'b00. This persists until the next start.
- R8: start_i asserted while a run is in progress is ignored: the run's sequence, length and seed count are unchanged.
- R9: A start with seed_count_i = 0 sets done_o in the next cycle without any load, twist or rotate cycle.
- R10: An accepted start with a nonzero seed count clears done_o in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, honoured only while idle |
| seed_count_i | input | SEED_W | Number of seeds for the run, sampled at start |
| state_o | output | 2 | Controller state: 00 load, 01 first twist half, 10 second twist half, 11 rotate |
| reg_op_o | output | 2 | Register operation: 00 hold, 01 serial load, 10 twist, 11 rotate |
| twist_cnt_en_o | output | 1 | Enable for the twist-length counter |
| shift_cnt_en_o | output | 1 | Enable for the rotate counter |
| seed_adv_o | output | 1 | Seed-advance pulse in the last cycle of a seed |
| pat_valid_o | output | 1 | An applied pattern is present in the register this cycle |
| done_o | output | 1 | All programmed seeds have been applied |

## Verification
Every output is a decode of registered state. The first cycle after the clock edge that samples an accepted start is already the first load cycle. done_o rises one cycle after the final rotate cycle. The bench numbers cycles from the start edge and samples on the falling edge. For each cycle it computes the expected phase from the position within the 2N²+2N cycle seed period, and it runs two instances with different N against the same stimulus. Extra start pulses are placed strictly inside a run, and the per-run count of non-hold cycles is compared against the seed count times the seed period.

// File: rtl/bist_seq_pkg.sv
// Shared encodings for the twisted-ring sequencing controller.
// Assumes: state codes are fixed because the register steering logic decodes them.
package bist_seq_pkg;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'b00,
        ST_TW1   = 2'b01,
        ST_TW2   = 2'b10,
        ST_SHIFT = 2'b11
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'b00,
        OP_LOAD  = 2'b01,
        OP_TWIST = 2'b10,
        OP_SHIFT = 2'b11
    } reg_op_e;

endpackage

// File: rtl/bist_seq_cnt.sv
// Enabled modulo counter with a terminal flag.
// Counts 0..LIMIT-1 while en is high, wraps to 0, and clears on clr.
// Assumes: LIMIT >= 2 and LIMIT <= 2**W.
module bist_seq_cnt #(
    parameter int LIMIT = 8,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt_o,
    output logic         last_o
);

    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    // Count register: clear has priority, then wrap-around increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr) begin
            cnt_o <= '0;
        end else if (en) begin
            cnt_o <= (cnt_o == TOP) ? '0 : cnt_o + 1'b1;
        end
    end

    // Terminal value flag.
    assign last_o = (cnt_o == TOP);

endmodule

// File: rtl/bist_seq_seeds.sv
// Seed run tracker: latches the programmed seed count at an accepted start
// and counts completed seeds.
// Assumes: adv_i pulses once per completed seed; total is nonzero when used.
module bist_seq_seeds #(
    parameter int SEED_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_acc_i,
    input  logic [SEED_W-1:0] seed_count_i,
    input  logic              adv_i,
    output logic              last_o
);

    logic [SEED_W-1:0] total_q;
    logic [SEED_W-1:0] idx_q;

    // Latch the run length when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_q <= '0;
        end else if (start_acc_i) begin
            total_q <= seed_count_i;
        end
    end

    // Index of the seed currently being applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (start_acc_i) begin
            idx_q <= '0;
        end else if (adv_i) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Current seed is the final one of the run.
    assign last_o = (idx_q == total_q - 1'b1);

endmodule

// File: rtl/bist_seq_fsm.sv
// Moore controller: load -> (twist half 1, twist half 2, rotate) x N -> next seed.
// Assumes: counter flags come from counters cleared at each accepted start.
module bist_seq_fsm
    import bist_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       zero_cnt_i,
    input  logic       load_last_i,
    input  logic       tw_half_i,
    input  logic       tw_last_i,
    input  logic       sh_last_i,
    input  logic       seed_last_i,
    output seq_state_e state_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       start_acc_o,
    output logic       load_en_o,
    output logic       tw_en_o,
    output logic       sh_en_o,
    output logic       adv_o
);

    seq_state_e state_q, state_d;
    logic       busy_q, done_q;
    logic       run_end;

    // Start is honoured only when no run is in progress.
    assign start_acc_o = start_i && !busy_q;

    // Phase enables decoded from the state register.
    assign load_en_o = busy_q && (state_q == ST_LOAD);
    assign tw_en_o   = (state_q == ST_TW1) || (state_q == ST_TW2);
    assign sh_en_o   = (state_q == ST_SHIFT);
    assign adv_o     = sh_en_o && sh_last_i;
    assign run_end   = adv_o && seed_last_i;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:  if (busy_q && load_last_i) state_d = ST_TW1;
            ST_TW1:   if (tw_half_i)             state_d = ST_TW2;
            ST_TW2:   if (tw_last_i)             state_d = ST_SHIFT;
            ST_SHIFT: state_d = sh_last_i ? ST_LOAD : ST_TW1;
            default:  state_d = ST_LOAD;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    // Run-in-progress flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                         busy_q <= 1'b0;
        else if (start_acc_o && !zero_cnt_i) busy_q <= 1'b1;
        else if (run_end)                   busy_q <= 1'b0;
    end

    // Completion flag: set at run end or at an empty start, cleared by a real start.
    always_ff @(posedge clk) begin
        if (!rst_n)           done_q <= 1'b0;
        else if (start_acc_o) done_q <= zero_cnt_i;
        else if (run_end)     done_q <= 1'b1;
    end

    assign state_o = state_q;
    assign busy_o  = busy_q;
    assign done_o  = done_q;

endmodule

// File: rtl/bist_seq_ctrl.sv
// Top of the twisted-ring pattern sequencing controller.
// Instantiates the load, twist and rotate counters, the seed tracker and the FSM,
// and decodes the register operation.
// Assumes: N >= 2; SEED_W wide enough for the largest seed count.
module bist_seq_ctrl
    import bist_seq_pkg::*;
#(
    parameter int N      = 8,
    parameter int SEED_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SEED_W-1:0] seed_count_i,
    output logic [1:0]        state_o,
    output logic [1:0]        reg_op_o,
    output logic              twist_cnt_en_o,
    output logic              shift_cnt_en_o,
    output logic              seed_adv_o,
    output logic              pat_valid_o,
    output logic              done_o
);

    localparam int KL = (N > 1) ? $clog2(N) : 1;
    localparam int KT = KL + 1;

    seq_state_e    state;
    reg_op_e       op;
    logic          busy, start_acc, load_en, tw_en, sh_en, adv;
    logic          load_last, tw_last, sh_last, seed_last, tw_half;
    logic [KL-1:0] load_cnt, sh_cnt;
    logic [KT-1:0] tw_cnt;

    bist_seq_cnt #(.LIMIT(N), .W(KL)) u_load_cnt (
        .clk(clk), .rst_n(rst_n), .clr(start_acc), .en(load_en),
        .cnt_o(load_cnt), .last_o(load_last)
    );

    bist_seq_cnt #(.LIMIT(2 * N), .W(KT)) u_twist_cnt (
        .clk(clk), .rst_n(rst_n), .clr(start_acc), .en(tw_en),
        .cnt_o(tw_cnt), .last_o(tw_last)
    );

    bist_seq_cnt #(.LIMIT(N), .W(KL)) u_shift_cnt (
        .clk(clk), .rst_n(rst_n), .clr(start_acc), .en(sh_en),
        .cnt_o(sh_cnt), .last_o(sh_last)
    );

    // End of the first twist half.
    assign tw_half = (tw_cnt == KT'(N - 1));

    bist_seq_seeds #(.SEED_W(SEED_W)) u_seeds (
        .clk(clk), .rst_n(rst_n), .start_acc_i(start_acc),
        .seed_count_i(seed_count_i), .adv_i(adv), .last_o(seed_last)
    );

    bist_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .zero_cnt_i(seed_count_i == '0),
        .load_last_i(load_last), .tw_half_i(tw_half), .tw_last_i(tw_last),
        .sh_last_i(sh_last), .seed_last_i(seed_last),
        .state_o(state), .busy_o(busy), .done_o(done_o),
        .start_acc_o(start_acc), .load_en_o(load_en),
        .tw_en_o(tw_en), .sh_en_o(sh_en), .adv_o(adv)
    );

    // Register operation decode; load state without a run means hold.
    always_comb begin
        unique case (state)
            ST_LOAD:        op = busy ? OP_LOAD : OP_HOLD;
            ST_TW1, ST_TW2: op = OP_TWIST;
            ST_SHIFT:       op = OP_SHIFT;
            default:        op = OP_HOLD;
        endcase
    end

    assign state_o        = state;
    assign reg_op_o       = op;
    assign twist_cnt_en_o = tw_en;
    assign shift_cnt_en_o = sh_en;
    assign seed_adv_o     = adv;
    assign pat_valid_o    = tw_en || sh_en;

endmodule

// File: rtl/bist_seq_ctrl_chk.sv
// Property checker for bist_seq_ctrl, attached by bind.
// Tracks run lengths of load and twist phases with its own counters.
module bist_seq_ctrl_chk #(
    parameter int N = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] state_o,
    input logic [1:0] reg_op_o,
    input logic       twist_cnt_en_o,
    input logic       seed_adv_o,
    input logic       pat_valid_o,
    input logic       done_o
);

    localparam int RW = $clog2(2 * N) + 2;

    logic [RW-1:0] load_run, twist_run;

    // Consecutive load cycles seen before the current one.
    always_ff @(posedge clk) begin
        if (!rst_n)                load_run <= '0;
        else if (reg_op_o == 2'b01) load_run <= load_run + 1'b1;
        else                       load_run <= '0;
    end

    // Consecutive twist cycles seen before the current one.
    always_ff @(posedge clk) begin
        if (!rst_n)                twist_run <= '0;
        else if (reg_op_o == 2'b10) twist_run <= twist_run + 1'b1;
        else                       twist_run <= '0;
    end

    assert_load_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_op_o == 2'b01 && load_run == RW'(N - 1)) |=> reg_op_o == 2'b10);
    assert_load_cont_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_op_o == 2'b01 && load_run < RW'(N - 1)) |=> reg_op_o == 2'b01);
    assert_twist_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_op_o == 2'b10 && twist_run == RW'(2 * N - 1)) |=> reg_op_o == 2'b11);
    assert_twist_cont_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_op_o == 2'b10 && twist_run < RW'(2 * N - 1)) |=> reg_op_o == 2'b10);
    assert_twist_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b01) |-> twist_cnt_en_o);
    assert_shift_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_op_o == 2'b11) |=> reg_op_o != 2'b11);
    assert_adv_in_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seed_adv_o |-> state_o == 2'b11);
    assert_valid_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pat_valid_o |-> state_o != 2'b00);
    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> reg_op_o == 2'b00);

endmodule

bind bist_seq_ctrl bist_seq_ctrl_chk #(.N(N)) chk_i (
    .clk(clk), .rst_n(rst_n), .state_o(state_o), .reg_op_o(reg_op_o),
    .twist_cnt_en_o(twist_cnt_en_o), .seed_adv_o(seed_adv_o),
    .pat_valid_o(pat_valid_o), .done_o(done_o)
);

// File: tb/bist_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: two controllers (N=4 and N=3) driven by the same start stream.
module bist_seq_ctrl_tb_top;

    localparam int SW = 4;
    localparam int NA = 4;
    localparam int NB = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [SW-1:0] cnt = '0;

    logic [1:0] st_a, op_a, st_b, op_b;
    logic       tw_a, sh_a, adv_a, pv_a, dn_a;
    logic       tw_b, sh_b, adv_b, pv_b, dn_b;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bist_seq_ctrl #(.N(NA), .SEED_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .seed_count_i(cnt),
        .state_o(st_a), .reg_op_o(op_a), .twist_cnt_en_o(tw_a),
        .shift_cnt_en_o(sh_a), .seed_adv_o(adv_a), .pat_valid_o(pv_a), .done_o(dn_a)
    );

    bist_seq_ctrl #(.N(NB), .SEED_W(SW)) dut2_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .seed_count_i(cnt),
        .state_o(st_b), .reg_op_o(op_b), .twist_cnt_en_o(tw_b),
        .shift_cnt_en_o(sh_b), .seed_adv_o(adv_b), .pat_valid_o(pv_b), .done_o(dn_b)
    );

    function automatic int seed_len(int n);
        return 2 * n * n + 2 * n;
    endfunction

    // Expected state code at position pos inside one seed period.
    function automatic int exp_state(int n, int pos);
        int r;
        if (pos < n) return 0;
        r = (pos - n) % (2 * n + 1);
        if (r < n)     return 1;
        if (r < 2 * n) return 2;
        return 3;
    endfunction

    task automatic chk(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Compare one instance's outputs in cycle c of a run of `total` cycles.
    task automatic check_dut(int n, int c, int total, logic [1:0] st, logic [1:0] op,
                             logic tw, logic sh, logic adv, logic pv, logic dn);
        int    es, eo, pos;
        string tag;
        if (c > total) begin
            tag = (total == 0) ? "R9" : "R7";
            chk(tag, "idle state", st, 0);
            chk(tag, "idle op", op, 0);
            chk(tag, "done", dn, 1);
            chk("R6", "idle valid", pv, 0);
            chk(tag, "idle adv", adv, 0);
            chk(tag, "idle twist en", tw, 0);
            chk(tag, "idle shift en", sh, 0);
        end else begin
            pos = (c - 1) % seed_len(n);
            es  = exp_state(n, pos);
            eo  = (es == 0) ? 1 : ((es == 3) ? 3 : 2);
            tag = (es == 0) ? "R2" : ((es == 3) ? "R4" : "R3");
            chk(tag, "state", st, es);
            chk(tag, "reg op", op, eo);
            chk(tag, "twist en", tw, int'(es == 1 || es == 2));
            chk(tag, "shift en", sh, int'(es == 3));
            chk("R5", "seed adv", adv, int'(pos == seed_len(n) - 1));
            chk("R6", "pattern valid", pv, int'(es != 0));
            chk("R10", "done low during run", dn, 0);
        end
    endtask

    // One run: start with `seeds`, optional extra start at cycle pulse_at (R8).
    task automatic run(int seeds, int pulse_at);
        int ta, tb, lim, act_a, act_b;
        ta = seeds * seed_len(NA);
        tb = seeds * seed_len(NB);
        lim = ((ta > tb) ? ta : tb) + 3;
        act_a = 0;
        act_b = 0;
        @(negedge clk);
        start = 1'b1;
        cnt = SW'(seeds);
        for (int c = 1; c <= lim; c++) begin
            @(negedge clk);
            start = 1'b0;
            if (c == pulse_at) begin
                start = 1'b1;          // R8: ignored while busy
                cnt = SW'(seeds + 1);
            end
            check_dut(NA, c, ta, st_a, op_a, tw_a, sh_a, adv_a, pv_a, dn_a);
            check_dut(NB, c, tb, st_b, op_b, tw_b, sh_b, adv_b, pv_b, dn_b);
            if (op_a != 2'b00) act_a++;
            if (op_b != 2'b00) act_b++;
        end
        chk("R5", "active cycles N=4", act_a, ta);
        chk("R5", "active cycles N=3", act_b, tb);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: got 0 expected 1 (run completion)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int s, p;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "state", st_a, 0);
        chk("R1", "reg op", op_a, 0);
        chk("R1", "done", dn_a, 0);
        chk("R1", "strobes", {tw_a, sh_a, adv_a, pv_a}, 0);
        chk("R1", "state N=3", st_b, 0);
        chk("R1", "done N=3", dn_b, 0);
        // Directed corners
        run(1, 0);
        run(0, 0);      // R9: empty start
        run(3, 5);      // R8: start during load
        run(2, 30);     // R8: start during twist
        run(15, 0);     // largest seed count
        // Random runs
        for (int i = 0; i < 10; i++) begin
            s = $urandom_range(1, 6);
            p = ($urandom_range(0, 1) == 1) ? $urandom_range(1, s * seed_len(NB) - 1) : 0;
            run(s, p);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule